// File: doc/BRIEF.md
# SDRAM Nibble Data Path with Byte-Lane Style Masking

This block is the data half of a four-bit-wide synchronous DRAM interface. A write beat puts one nibble into a small internal store at the column address given with it. A read beat fetches a nibble and shows it at the data outputs after a programmable number of clocks, the CAS latency, which is either two or three. The data bus is bidirectional at the pins. This model keeps the input and output directions apart and has an output-enable signal that turns on the pin driver.

One mask input, `dqm`, acts differently on the two directions. On a write beat it blocks the nibble on the same clock edge. On reads it works on a fixed two-clock delay that does not depend on the CAS latency. The output driver is then switched off for the data that would have appeared two clocks after the edge where `dqm` was sampled. A controller uses the mask to skip single beats of a burst in either direction.

Top module: `sdram_dq_path`

## Requirements
- R1: A write beat sampled with `dqm` low stores `wr_data` at `col_addr` on that same edge, and a later read of that address returns it.
- R2: A write beat sampled with `dqm` high leaves the stored nibble at `col_addr` unchanged (mask latency zero for writes).
- R3: With `cas_lat3` = 0 (latency 2), a read beat sampled at edge k shows the stored nibble with `rd_valid` high for exactly the cycle that follows edge k+2.
- R4: With `cas_lat3` = 1 (latency 3), a read beat sampled at edge k shows the stored nibble with `rd_valid` high for exactly the cycle that follows edge k+3.
- R5: `dqm` high at edge j blanks the output cycle that follows edge j+2, whatever the latency. In that cycle `rd_valid` and `dq_oe` are low and `rd_data` is zero. `dqm` at other edges does not blank that cycle.
- R6: `dq_oe` is high exactly in the cycles where `rd_valid` is high, and `rd_data` is zero whenever `rd_valid` is low.
- R7: During and right after reset, `rd_valid`, `dq_oe` and `rd_data` are low, and every stored nibble reads back as zero.
- R8: Read beats on consecutive edges produce valid data on consecutive cycles with no gap, in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_beat | input | 1 | Write beat strobe |
| rd_beat | input | 1 | Read beat strobe |
| col_addr | input | 4 | Column address of the beat |
| cas_lat3 | input | 1 | Latency select: 0 = two clocks, 1 = three clocks |
| dqm | input | 1 | Data mask (latency 0 on writes, 2 on reads) |
| wr_data | input | 4 | Write nibble |
| rd_data | output | 4 | Read nibble, zero when not valid |
| rd_valid | output | 1 | Read nibble valid |
| dq_oe | output | 1 | Output driver enable for the shared pins |

## Verification
A slip of one stage in the latency delay line shows up as valid data one cycle early or late. That is visible at `rd_valid` in the first read of the affected latency. A wrong depth in the mask delay line blanks the wrong beat of a burst, so a four-beat burst with one masked slot exposes it within four cycles. Any corrupt entry in the store stays hidden until that address is read back, so every write and every masked write is followed by a read of the same address.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  localparam int unsigned CL_SHORT    = 2;
  localparam int unsigned CL_LONG     = 3;
  localparam int unsigned RD_MASK_LAT = 2;

  // index of the delay-line stage that feeds the output register
  function automatic logic [1:0] cl_tap(input logic sel_long);
    return sel_long ? 2'(CL_LONG - 1) : 2'(CL_SHORT - 1);
  endfunction

  // a beat is shown only when it is valid and not masked
  function automatic logic beat_shown(input logic vld, input logic masked);
    return vld & ~masked;
  endfunction
endpackage

// File: rtl/sdq_store.sv
module sdq_store #(
  parameter int unsigned DQ_W  = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_mask,
  input  logic [AW-1:0]   addr,
  input  logic [DQ_W-1:0] wr_data,
  output logic [DQ_W-1:0] rd_word
);
  logic [DQ_W-1:0] mem [DEPTH];
  logic            wr_commit;

  assign wr_commit = wr_en & ~wr_mask;
  assign rd_word   = mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_commit) begin
      mem[addr] <= wr_data;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mask) |=> mem[$past(addr)] == $past(wr_data)); // R1
  AST_MASKED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mask) |=> mem[$past(addr)] == $past(rd_word)); // R2
endmodule

// File: rtl/sdq_cas_line.sv
module sdq_cas_line
  import sdq_pkg::*;
#(
  parameter int unsigned DQ_W   = 4,
  parameter int unsigned STAGES = CL_LONG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [DQ_W-1:0] in_data,
  input  logic            sel_long,
  output logic            tap_vld,
  output logic [DQ_W-1:0] tap_data
);
  logic            stg_vld [STAGES];
  logic [DQ_W-1:0] stg_dat [STAGES];
  logic [1:0]      tap;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_vld[0] <= 1'b0;
          stg_dat[0] <= '0;
        end else begin
          stg_vld[0] <= in_vld;
          stg_dat[0] <= in_data;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_vld[g] <= 1'b0;
          stg_dat[g] <= '0;
        end else begin
          stg_vld[g] <= stg_vld[g-1];
          stg_dat[g] <= stg_dat[g-1];
        end
      end
    end
  end

  assign tap      = cl_tap(sel_long);
  assign tap_vld  = stg_vld[tap];
  assign tap_data = stg_dat[tap];
endmodule

// File: rtl/sdq_mask_line.sv
module sdq_mask_line #(
  parameter int unsigned LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dqm,
  output logic dqm_late
);
  logic dly [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n)      dly[g] <= 1'b0;
      else if (g == 0) dly[g] <= dqm;
      else             dly[g] <= dly[(g == 0) ? 0 : g-1];
    end
  end

  assign dqm_late = dly[LAT-1];
endmodule

// File: rtl/sdram_dq_path.sv
module sdram_dq_path
  import sdq_pkg::*;
#(
  parameter int unsigned DQ_W  = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_beat,
  input  logic            rd_beat,
  input  logic [AW-1:0]   col_addr,
  input  logic            cas_lat3,
  input  logic            dqm,
  input  logic [DQ_W-1:0] wr_data,
  output logic [DQ_W-1:0] rd_data,
  output logic            rd_valid,
  output logic            dq_oe
);
  logic [DQ_W-1:0] fetched;
  logic            tap_vld;
  logic [DQ_W-1:0] tap_data;
  logic            dqm_late;
  logic            show_beat;
  logic            masked_beat;

  sdq_store #(.DQ_W(DQ_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_beat),
    .wr_mask (dqm),
    .addr    (col_addr),
    .wr_data (wr_data),
    .rd_word (fetched)
  );

  sdq_cas_line #(.DQ_W(DQ_W), .STAGES(CL_LONG)) u_cas (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (rd_beat),
    .in_data  (fetched),
    .sel_long (cas_lat3),
    .tap_vld  (tap_vld),
    .tap_data (tap_data)
  );

  sdq_mask_line #(.LAT(RD_MASK_LAT)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .dqm      (dqm),
    .dqm_late (dqm_late)
  );

  assign show_beat   = beat_shown(tap_vld, dqm_late);
  assign masked_beat = tap_vld & dqm_late;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      dq_oe    <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= show_beat;
      dq_oe    <= show_beat;
      rd_data  <= show_beat ? tap_data : '0;
    end
  end

  AST_CL2_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_beat, 3) && !$past(dqm, 3) && !cas_lat3 && $past(!cas_lat3, 3))
      |-> rd_valid); // R3
  AST_CL3_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_beat, 4) && !$past(dqm, 3) && cas_lat3 && $past(cas_lat3, 4))
      |-> rd_valid); // R4
  AST_DQM_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dqm, 3) |-> (!rd_valid && !dq_oe)); // R5
  AST_OE_TRACKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe == rd_valid); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0); // R6
endmodule

// File: tb/sdram_dq_path_bench.sv
`timescale 1ns/1ps
module sdram_dq_path_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_beat = 1'b0, rd_beat = 1'b0, cas_lat3 = 1'b0, dqm = 1'b0;
  logic [3:0] col_addr = '0, wr_data = '0;
  logic [3:0] rd_data;
  logic       rd_valid, dq_oe;
  int         n_chk = 0, n_bad = 0;
  logic [3:0] model [16];

  always #2.5 clk = ~clk;

  sdram_dq_path u_sdram_dq_path (
    .clk(clk), .rst_n(rst_n), .wr_beat(wr_beat), .rd_beat(rd_beat),
    .col_addr(col_addr), .cas_lat3(cas_lat3), .dqm(dqm), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .dq_oe(dq_oe)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  // every check also covers R6: oe follows valid, data zero when idle
  task automatic chk(string req, logic v_exp, logic [3:0] d_exp);
    n_chk++;
    if (rd_valid !== v_exp || dq_oe !== v_exp || rd_data !== d_exp) begin
      n_bad++;
      $display("FAIL %s: valid=%b oe=%b data=%h, expected valid=%b oe=%b data=%h",
               req, rd_valid, dq_oe, rd_data, v_exp, v_exp, d_exp);
    end
  endtask

  task automatic do_write(logic [3:0] a, logic [3:0] d, logic m);
    wr_beat = 1'b1; col_addr = a; wr_data = d; dqm = m;
    step();
    wr_beat = 1'b0; dqm = 1'b0;
    if (!m) model[a] = d;
  endtask

  task automatic rd_check(string req, logic [3:0] a, logic long_lat);
    int lat;
    lat = long_lat ? 3 : 2;
    cas_lat3 = long_lat; rd_beat = 1'b1; col_addr = a;
    step();
    rd_beat = 1'b0;
    repeat (lat - 1) step();
    chk(req, 1'b0, 4'h0);
    step();
    chk(req, 1'b1, model[a]);
    step();
    chk(req, 1'b0, 4'h0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) model[i] = 4'h0;
    rst_n = 1'b0;
    repeat (3) step();
    chk("R7 in reset", 1'b0, 4'h0);
    rst_n = 1'b1;
    step();
    chk("R7 after reset", 1'b0, 4'h0);
    rd_check("R7 cleared store", 4'd9, 1'b0);
  endtask

  task automatic t_write_read();
    do_write(4'd1, 4'hA, 1'b0);
    do_write(4'd2, 4'h5, 1'b0);
    do_write(4'd3, 4'h3, 1'b0);
    do_write(4'd4, 4'hC, 1'b0);
    rd_check("R1 R3 addr1", 4'd1, 1'b0);
    rd_check("R1 R3 addr4", 4'd4, 1'b0);
  endtask

  task automatic t_cl3();
    rd_check("R4 addr2", 4'd2, 1'b1);
    rd_check("R4 addr3", 4'd3, 1'b1);
  endtask

  task automatic t_write_mask();
    do_write(4'd3, 4'hF, 1'b1);
    rd_check("R2 masked write", 4'd3, 1'b0);
    do_write(4'd15, 4'h6, 1'b0);
    do_write(4'd15, 4'h9, 1'b1);
    rd_check("R2 masked overwrite", 4'd15, 1'b1);
  endtask

  task automatic t_read_mask();
    // latency 2: mask with the command blanks its own data
    cas_lat3 = 1'b0; rd_beat = 1'b1; col_addr = 4'd1; dqm = 1'b1;
    step();
    rd_beat = 1'b0; dqm = 1'b0;
    step(); chk("R5 cl2 early", 1'b0, 4'h0);
    step(); chk("R5 cl2 masked", 1'b0, 4'h0);
    // latency 3: mask one edge after the command blanks the data
    cas_lat3 = 1'b1; rd_beat = 1'b1; col_addr = 4'd2;
    step();
    rd_beat = 1'b0; dqm = 1'b1;
    step();
    dqm = 1'b0;
    step(); chk("R5 cl3 early", 1'b0, 4'h0);
    step(); chk("R5 cl3 masked", 1'b0, 4'h0);
    // latency 3: mask with the command hits an empty slot, data still shown
    rd_beat = 1'b1; col_addr = 4'd4; dqm = 1'b1;
    step();
    rd_beat = 1'b0; dqm = 1'b0;
    step(); step(); chk("R5 cl3 other edge", 1'b0, 4'h0);
    step(); chk("R5 cl3 unmasked", 1'b1, model[4]);
    step(); chk("R5 cl3 after", 1'b0, 4'h0);
  endtask

  task automatic t_burst();
    cas_lat3 = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rd_beat = 1'b1; col_addr = 4'(i + 1); dqm = (i == 2);
      step();
    end
    rd_beat = 1'b0; dqm = 1'b0;
    chk("R8 beat0", 1'b1, model[1]);
    step(); chk("R8 R5 beat1 masked", 1'b0, 4'h0);
    step(); chk("R8 beat2", 1'b1, model[3]);
    step(); chk("R8 beat3", 1'b1, model[4]);
    step(); chk("R8 end", 1'b0, 4'h0);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_cl3();
    t_write_mask();
    t_read_mask();
    t_burst();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule